// File: doc/BRIEF.md
# Carry-Select Adder and Accumulator Cell Chain

This block adds two N-bit operands and a carry-in with a chain of arithmetic cells. Each cell holds four 2-input lookup tables fed by its two operand bits. Two tables give the sum bit for an incoming carry of zero and of one. The other two give the carry-out for each of those assumed carries. Two carry chains run in parallel down the group. One starts from a forced zero and one from a forced one. The group carry-in then decides which chain's carry picks each cell's sum bit, and which chain's last carry becomes the carry-out. Nothing waits on a single ripple that begins at the carry-in.

Every cell gives its sum both combinationally and from a register. The register loads on a clock enable and has a synchronous clear. When accumulation is selected, the registered sum replaces the second operand, so the block adds the first operand into a running total on every enabled clock.

Top module: `csel_accum_top`

## Requirements
- R1: With accumEn low, sumComb equals the low WIDTH bits of opA + opB + carryIn, where carryIn counts as 0 or 1.
- R2: carryOut equals bit WIDTH of the same full sum, which is 1 exactly when the addition overflows WIDTH bits.
- R3: With accumEn high, the second operand is sumReg in place of opB. sumComb and carryOut then follow opA + sumReg + carryIn.
- R4: On a rising clock edge with clkEn high and clear low, sumReg takes the value sumComb had just before that edge.
- R5: On a rising clock edge with clkEn low and clear low, sumReg keeps its value.
- R6: On a rising clock edge with clear high, sumReg becomes zero whatever clkEn is. Clear has priority over the load.
- R7: While rstN is low, sumReg is zero at once, without waiting for a clock edge.
- R8: A carry that must travel through every bit position gives the correct result. All-ones plus zero with carry-in 1 gives sum 0 and carryOut 1. All-ones plus all-ones with carry-in 1 gives all-ones and carryOut 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand, used when accumEn is low |
| carryIn | input | 1 | Group carry-in; chooses between the two carry chains |
| clkEn | input | 1 | Load enable for the sum register |
| clear | input | 1 | Synchronous clear of the sum register |
| accumEn | input | 1 | Feed sumReg back in place of opB |
| sumComb | output | WIDTH | Combinational sum |
| sumReg | output | WIDTH | Registered sum |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
Operand pairs where every bit propagates, such as all-ones plus zero or alternating bit patterns, force the group carry-in to decide every sum bit. These pairs expose a chain seeded or selected the wrong way. Pairs where every bit generates or kills a carry, such as all-ones plus all-ones or two top-bit-only values, separate the generate table from the propagate table and test overflow into carryOut. Random operands with random enable, clear and feedback settings are compared every cycle against a behavioural model. This shows whether the load, hold, clear priority and feedback choose the right register value, and checks the second operand in both modes.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic loadNow;   // load sumReg from the combinational sum
    logic clearNow;  // force sumReg to zero
    logic feedBack;  // use sumReg as the second operand
  } cselStrobe_t;

  // Lookup masks of one arithmetic cell, indexed by {a, b}
  localparam logic [3:0] SUM_IF_ZERO_MASK   = 4'b0110; // a ^ b
  localparam logic [3:0] SUM_IF_ONE_MASK    = 4'b1001; // ~(a ^ b)
  localparam logic [3:0] CARRY_IF_ZERO_MASK = 4'b1000; // a & b
  localparam logic [3:0] CARRY_IF_ONE_MASK  = 4'b1110; // a | b

endpackage

// File: rtl/csel_cell.sv
module csel_cell
  import csel_pkg::*;
#(
  parameter logic [3:0] SUM0_MASK   = SUM_IF_ZERO_MASK,
  parameter logic [3:0] SUM1_MASK   = SUM_IF_ONE_MASK,
  parameter logic [3:0] CARRY0_MASK = CARRY_IF_ZERO_MASK,
  parameter logic [3:0] CARRY1_MASK = CARRY_IF_ONE_MASK
) (
  input  logic aBit,
  input  logic bBit,
  input  logic chainIn0,
  input  logic chainIn1,
  input  logic groupCarry,
  output logic chainOut0,
  output logic chainOut1,
  output logic sumBit
);

  logic [1:0] lutIdx;
  logic       sumIfZero;
  logic       sumIfOne;
  logic       carryIfZero;
  logic       carryIfOne;
  logic       pickedCarry;

  assign lutIdx = {aBit, bBit};

  // Four 2-input lookup tables
  assign sumIfZero   = SUM0_MASK[lutIdx];
  assign sumIfOne    = SUM1_MASK[lutIdx];
  assign carryIfZero = CARRY0_MASK[lutIdx];
  assign carryIfOne  = CARRY1_MASK[lutIdx];

  // Each chain's incoming carry picks that chain's outgoing carry
  assign chainOut0 = chainIn0 ? carryIfOne : carryIfZero;
  assign chainOut1 = chainIn1 ? carryIfOne : carryIfZero;

  // The group carry picks the chain, and that chain's level picks the sum
  assign pickedCarry = groupCarry ? chainIn1 : chainIn0;
  assign sumBit      = pickedCarry ? sumIfOne : sumIfZero;

endmodule

// File: rtl/csel_control.sv
module csel_control
  import csel_pkg::*;
(
  input  logic        clkEn,
  input  logic        clear,
  input  logic        accumEn,
  output cselStrobe_t strobe
);

  always_comb begin
    strobe.clearNow = clear;
    strobe.loadNow  = clkEn & ~clear;   // clear has priority over load
    strobe.feedBack = accumEn;
  end

endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cselStrobe_t       strobe,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              carryIn,
  output logic [WIDTH-1:0]  operandB,
  output logic [WIDTH-1:0]  sumComb,
  output logic [WIDTH-1:0]  sumReg,
  output logic              carryOut
);

  localparam int CHAIN_LEN = WIDTH + 1;

  logic [CHAIN_LEN-1:0] chainZero;
  logic [CHAIN_LEN-1:0] chainOne;

  assign operandB     = strobe.feedBack ? sumReg : opB;
  assign chainZero[0] = 1'b0;
  assign chainOne[0]  = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : gCell
    csel_cell cell_i (
      .aBit       (opA[i]),
      .bBit       (operandB[i]),
      .chainIn0   (chainZero[i]),
      .chainIn1   (chainOne[i]),
      .groupCarry (carryIn),
      .chainOut0  (chainZero[i+1]),
      .chainOut1  (chainOne[i+1]),
      .sumBit     (sumComb[i])
    );
  end

  assign carryOut = carryIn ? chainOne[WIDTH] : chainZero[WIDTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sumReg <= '0;
    else if (strobe.clearNow) sumReg <= '0;
    else if (strobe.loadNow)  sumReg <= sumComb;
  end

  // R1
  chain_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chainZero & ~chainOne) == '0);

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadNow |=> sumReg == $past(sumComb));

  // R5
  hold_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadNow && !strobe.clearNow) |=> $stable(sumReg));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearNow |=> sumReg == '0);

endmodule

// File: rtl/csel_accum_top.sv
module csel_accum_top
  import csel_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             clkEn,
  input  logic             clear,
  input  logic             accumEn,
  output logic [WIDTH-1:0] sumComb,
  output logic [WIDTH-1:0] sumReg,
  output logic             carryOut
);

  localparam int FULL_W = WIDTH + 1;

  cselStrobe_t      strobe;
  logic [WIDTH-1:0] operandB;

  csel_control ctrl_i (
    .clkEn   (clkEn),
    .clear   (clear),
    .accumEn (accumEn),
    .strobe  (strobe)
  );

  csel_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .operandB (operandB),
    .sumComb  (sumComb),
    .sumReg   (sumReg),
    .carryOut (carryOut)
  );

  // R2
  direct_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accumEn |-> {carryOut, sumComb} ==
      (FULL_W'(opA) + FULL_W'(opB) + FULL_W'(carryIn)));

  // R3
  feedback_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    accumEn |-> {carryOut, sumComb} ==
      (FULL_W'(opA) + FULL_W'(sumReg) + FULL_W'(carryIn)));

endmodule

// File: tb/csel_accum_top_tb_top.sv
`timescale 1ns/1ps
module csel_accum_top_tb_top;

  localparam int W = 16;
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic         clkEn = 1'b0;
  logic         clear = 1'b0;
  logic         accumEn = 1'b0;
  logic [W-1:0] sumComb;
  logic [W-1:0] sumReg;
  logic         carryOut;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] modelReg = '0;

  always #2.5 clk = ~clk;

  csel_accum_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .clkEn(clkEn), .clear(clear), .accumEn(accumEn),
    .sumComb(sumComb), .sumReg(sumReg), .carryOut(carryOut)
  );

  task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check the combinational
  // result, then check the register after the rising edge
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic c, input logic en, input logic clr,
                      input logic acc, input string boundTag);
    logic [W:0] full;
    integer second;
    @(negedge clk);
    opA = a; opB = b; carryIn = c; clkEn = en; clear = clr; accumEn = acc;
    #1;
    second = acc ? modelReg : b;
    full = (W+1)'(a) + (W+1)'(second) + (W+1)'(c);
    if (boundTag != "") chk(boundTag, {carryOut, sumComb}, full);
    chk(acc ? "R3 sum" : "R1 sum", {1'b0, sumComb}, {1'b0, full[W-1:0]});
    chk("R2 carry", {{W{1'b0}}, carryOut}, {{W{1'b0}}, full[W]});
    @(posedge clk);
    if (clr) modelReg = '0;
    else if (en) modelReg = full[W-1:0];
    #1;
    chk(clr ? "R6 clear" : (en ? "R4 load" : "R5 hold"),
        {1'b0, sumReg}, {1'b0, modelReg});
  endtask

  initial begin : watchdog
    #500000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    chk("R7 reset", {1'b0, sumReg}, '0);
    @(negedge clk);
    rstN = 1'b1;

    // boundaries with carries that travel the whole width
    step(ALL1, '0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 propagate");
    step(ALL1, ALL1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 generate");
    step(16'hAAAA, 16'h5555, 1'b1, 1'b1, 1'b0, 1'b0, "R8 alternate");
    step(16'h8000, 16'h8000, 1'b0, 1'b1, 1'b0, 1'b0, "");
    step('0, '0, 1'b0, 1'b1, 1'b0, 1'b0, "");
    step(16'h1234, 16'h4321, 1'b0, 1'b0, 1'b0, 1'b0, ""); // hold R5
    step(16'h00FF, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, "");
    step(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, ""); // clear, no enable R6
    step(16'h0003, 16'h7777, 1'b0, 1'b1, 1'b1, 1'b0, ""); // clear beats load R6

    // running total R3
    for (int i = 0; i < 8; i++)
      step(16'h2003, 16'hDEAD, i[0], 1'b1, 1'b0, 1'b1, "");
    step(16'h0001, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, "");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = W'($urandom);
      rb = W'($urandom);
      step(ra, rb, 1'($urandom), 1'($urandom), ($urandom % 10) == 0,
           1'($urandom), "");
    end

    // asynchronous reset in mid-cycle R7
    step(16'h5A5A, 16'h0101, 1'b0, 1'b1, 1'b0, 1'b0, "");
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R7 async", {1'b0, sumReg}, '0);
    modelReg = '0;
    @(negedge clk);
    rstN = 1'b1;
    step(16'h0010, 16'h0020, 1'b1, 1'b1, 1'b0, 1'b0, "");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule